// File: doc/BRIEF.md
# Receive Frame-Sync Source Selector

This block produces the internal receive frame sync and receive clock of a buffered serial port. The frame sync can come from three places. The first is the external frame-sync pin. The second is a small on-block generator. The third is the transmit side, which is used when loopback or clock-stop operation reroutes the receive timing. The block also drives the frame-sync pin's output value and output enable, so the generated sync can be sent off chip.

The generator divides the receive clock pin by `clk_div + 1` to form a generated bit clock, and a period counter counts `frame_per + 1` of those generated cycles between frame syncs. In locked mode the generator stops free-running. A rising edge on the frame-sync pin passes through a two-flop synchronizer and an edge detector. It then reloads the divider and starts a single frame-sync pulse one generated cycle wide. The period setting has no effect in this mode.

Routing priority is fixed. Loopback or a clock-stop value with its upper bit set sends the transmit clock and transmit frame sync to the receive side. Otherwise the source-select bit chooses between the pin and the generator.

Top module: `rx_fsync_sel`

## Requirements
- R1: With `use_gen`=0 and no transmit routing, `rx_fs` follows `fs_pin_in` in the same cycle, `rx_clk` follows `clk_in`, and `fs_pin_oe` is 0.
- R2: With `use_gen`=1 and `lock_ext`=0, `fs_pin_oe` is 1, and `fs_pin_out` equals `rx_fs` in every mode.
- R3: In free-running mode, with G=`clk_div` and F=`frame_per`, sample n after reset release (n=0 is the first sample before any rising edge) has `rx_fs` high exactly when floor(n/(G+1)) mod (F+1) is 0.
- R4: With `use_gen`=1 and `lock_ext`=1, `fs_pin_oe` is 0 and `frame_per` is ignored. `rx_fs` stays low until the pin rises. If the pin first reads high just after rising edge k, `rx_fs` is high for exactly G+1 cycles starting after rising edge k+3.
- R5: In locked mode, every detected pin edge reloads the divider. Each pulse therefore lasts G+1 cycles counted from its own edge, whatever the divider phase was before.
- R6: With `loopback`=1, `rx_fs` equals `tx_fs` and `rx_clk` equals `tx_clk`, whatever the other settings are.
- R7: When `clk_stop`[1] is 1 (values 2'b10 and 2'b11), the transmit clock and frame sync are routed as in R6. The values 2'b00 and 2'b01 leave normal routing in place.
- R8: During reset all registered state is 0. The generator starts at the top of a period, so in free-running mode `rx_fs` is high for the first G+1 samples after release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Receive clock pin; also the clock of the generator |
| rst_n | input | 1 | Asynchronous active-low reset |
| use_gen | input | 1 | Frame-sync source select: 0 pin, 1 generator |
| lock_ext | input | 1 | Lock the generator to pin edges |
| loopback | input | 1 | Route receive timing from the transmit side |
| clk_stop | input | 2 | Clock-stop setting; upper bit set routes from the transmit side |
| clk_div | input | DIV_W | Generated clock divide value minus one |
| frame_per | input | PER_W | Frame period in generated cycles minus one |
| fs_pin_in | input | 1 | Frame-sync pin input |
| tx_clk | input | 1 | Internal transmit clock |
| tx_fs | input | 1 | Internal transmit frame sync |
| rx_clk | output | 1 | Internal receive clock |
| rx_fs | output | 1 | Internal receive frame sync |
| fs_pin_out | output | 1 | Frame-sync pin output value |
| fs_pin_oe | output | 1 | Frame-sync pin output enable |

## Verification
The bench compares every free-running sample against the closed-form period formula, using two divide and period settings, one of them with a divide of one. A counter off by one would show up as a stretched or shortened pulse.

In locked mode the bench sets a zero period, which a design that still used the period would turn into a constant high output. It also times two pin pulses so that the second lands mid-phase: a design that did not reload the divider would cut that pulse short. The synchronizer latency is pinned to three edges.

The routing checks hold the transmit clock and frame sync at values the normal path cannot show. They cover loopback, both clock-stop values that route, the clock-stop value that does not route, and the combination of loopback and clock-stop, so a wrong priority or a mis-decoded clock-stop bit changes the output.

// File: rtl/rx_fsync_sel.sv
module rx_fsync_sel #(
  parameter int DIV_W = 8,
  parameter int PER_W = 12
) (
  input  logic             clk_in,
  input  logic             rst_n,
  input  logic             use_gen,
  input  logic             lock_ext,
  input  logic             loopback,
  input  logic [1:0]       clk_stop,
  input  logic [DIV_W-1:0] clk_div,
  input  logic [PER_W-1:0] frame_per,
  input  logic             fs_pin_in,
  input  logic             tx_clk,
  input  logic             tx_fs,
  output logic             rx_clk,
  output logic             rx_fs,
  output logic             fs_pin_out,
  output logic             fs_pin_oe
);
  localparam int SYNC_N = 3;

  logic [SYNC_N-1:0] pin_sync;
  logic [DIV_W-1:0]  div_cnt;
  logic [PER_W-1:0]  per_cnt;
  logic              lock_pulse;

  wire pin_rise = pin_sync[1] & ~pin_sync[2];
  wire resync   = lock_ext & pin_rise;
  wire gen_tick = (div_cnt >= clk_div);
  wire gen_fs   = lock_ext ? lock_pulse : (per_cnt == '0);
  wire tx_route = loopback | clk_stop[1];

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n) pin_sync <= '0;
    else        pin_sync <= {pin_sync[SYNC_N-2:0], fs_pin_in};
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)        div_cnt <= '0;
    else if (resync)   div_cnt <= '0;
    else if (gen_tick) div_cnt <= '0;
    else               div_cnt <= div_cnt + 1'b1;
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)                 per_cnt <= '0;
    else if (resync)            per_cnt <= '0;
    else if (gen_tick) begin
      if (per_cnt >= frame_per) per_cnt <= '0;
      else                      per_cnt <= per_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk_in or negedge rst_n) begin
    if (!rst_n)        lock_pulse <= 1'b0;
    else if (resync)   lock_pulse <= 1'b1;
    else if (gen_tick) lock_pulse <= 1'b0;
  end

  assign rx_clk     = tx_route ? tx_clk : clk_in;
  assign rx_fs      = tx_route ? tx_fs : (use_gen ? gen_fs : fs_pin_in);
  assign fs_pin_out = rx_fs;
  assign fs_pin_oe  = use_gen & ~lock_ext;
endmodule

// File: rtl/rx_fsync_sel_chk.sv
module rx_fsync_sel_chk (
  input logic       clk_in,
  input logic       rst_n,
  input logic       use_gen,
  input logic       lock_ext,
  input logic       loopback,
  input logic [1:0] clk_stop,
  input logic       fs_pin_in,
  input logic       tx_clk,
  input logic       tx_fs,
  input logic       rx_clk,
  input logic       rx_fs,
  input logic       fs_pin_out,
  input logic       fs_pin_oe
);
  logic routed;
  assign routed = loopback | clk_stop[1];

  a_r1_pin_source: assert property (@(posedge clk_in) disable iff (!rst_n)
    (!routed && !use_gen) |-> (rx_fs == fs_pin_in && !fs_pin_oe));

  a_r2_pin_drive: assert property (@(posedge clk_in) disable iff (!rst_n)
    (use_gen && !lock_ext) |-> (fs_pin_oe && fs_pin_out == rx_fs));

  a_r4_no_drive: assert property (@(posedge clk_in) disable iff (!rst_n)
    (use_gen && lock_ext) |-> !fs_pin_oe);

  a_r4_needs_edge: assert property (@(posedge clk_in) disable iff (!rst_n)
    (use_gen && lock_ext && !routed && $past(use_gen && lock_ext && !routed) && $rose(rx_fs))
      |-> $past(fs_pin_in, 3));

  a_r6_loop: assert property (@(posedge clk_in) disable iff (!rst_n)
    loopback |-> (rx_fs == tx_fs));

  a_r7_stop: assert property (@(posedge clk_in) disable iff (!rst_n)
    clk_stop[1] |-> (rx_fs == tx_fs));
endmodule

bind rx_fsync_sel rx_fsync_sel_chk u_chk (.*);

// File: tb/rx_fsync_sel_test.sv
`timescale 1ns/100ps
module rx_fsync_sel_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic        use_gen = 0, lock_ext = 0, loopback = 0;
  logic [1:0]  clk_stop = 2'b00;
  logic [7:0]  clk_div = '0;
  logic [11:0] frame_per = '0;
  logic        fs_pin_in = 0, tx_clk = 0, tx_fs = 0;
  logic        rx_clk, rx_fs, fs_pin_out, fs_pin_oe;

  rx_fsync_sel #(.DIV_W(8), .PER_W(12)) uut (
    .clk_in(clk), .rst_n(rst_n), .use_gen(use_gen), .lock_ext(lock_ext),
    .loopback(loopback), .clk_stop(clk_stop), .clk_div(clk_div),
    .frame_per(frame_per), .fs_pin_in(fs_pin_in), .tx_clk(tx_clk),
    .tx_fs(tx_fs), .rx_clk(rx_clk), .rx_fs(rx_fs),
    .fs_pin_out(fs_pin_out), .fs_pin_oe(fs_pin_oe));

  logic [3:0] exp_q[$];
  int         req_q[$];
  int         vectors = 0, miscompares = 0;
  bit         done = 0;

  task automatic step(input logic fs, input logic oe, input logic rclk, input int req);
    exp_q.push_back({fs, oe, fs, rclk});
    req_q.push_back(req);
    @(posedge clk); #1;
  endtask

  task automatic apply_reset();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
  endtask

  initial begin
    forever begin
      @(negedge clk); #0.5;
      if (exp_q.size() != 0) begin
        logic [3:0] e, got;
        int r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        got = {rx_fs, fs_pin_oe, fs_pin_out, rx_clk};
        vectors++;
        if (got !== e) begin
          miscompares++;
          $display("FAIL R%0d: got %b expected %b (fs,oe,out,clk)", r, got, e);
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog: got hung run expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    @(posedge clk); #1;
    step(0, 0, 0, 8);  // R8 outputs while held in reset
    step(0, 0, 0, 8);  // R8
    apply_reset();

    tx_clk = 1; tx_fs = 1;
    for (int i = 0; i < 6; i++) begin
      fs_pin_in = i[0];
      step(i[0], 0, 0, 1);  // R1 pin passthrough, transmit side ignored
    end
    clk_stop = 2'b01;
    fs_pin_in = 0;
    step(0, 0, 0, 7);  // R7 value 01 keeps pin routing
    fs_pin_in = 1;
    step(1, 0, 0, 7);  // R7
    clk_stop = 2'b00; fs_pin_in = 0; tx_clk = 0; tx_fs = 0;

    use_gen = 1; lock_ext = 0; clk_div = 8'd2; frame_per = 12'd3;
    apply_reset();
    for (int n = 0; n < 30; n++) begin
      fs_pin_in = n[1];
      step(((n / 3) % 4) == 0, 1, 0, (n < 3) ? 8 : 3);  // R3 period, R8 start, R2 drive
    end

    clk_div = 8'd0; frame_per = 12'd4;
    apply_reset();
    for (int n = 0; n < 15; n++)
      step((n % 5) == 0, 1, 0, 3);  // R3 divide by one

    lock_ext = 1; clk_div = 8'd3; frame_per = 12'd0; fs_pin_in = 0;
    apply_reset();
    for (int n = 0; n < 40; n++) begin
      logic e1, e2;
      e1 = (n >= 9) && (n <= 12);
      e2 = (n >= 23) && (n <= 26);
      step(e1 | e2, 0, 0, e2 ? 5 : 4);  // R4 locked pulse, R5 reload on second edge
      if (n == 5 || n == 19) fs_pin_in = 1;
      if (n == 7 || n == 21) fs_pin_in = 0;
    end

    use_gen = 0; lock_ext = 0; loopback = 1;
    for (int i = 0; i < 4; i++) begin
      tx_fs = i[0]; tx_clk = i[1]; fs_pin_in = ~i[0];
      step(i[0], 0, i[1], 6);  // R6 loopback, pin source
    end
    use_gen = 1;
    for (int i = 0; i < 4; i++) begin
      tx_fs = i[1]; tx_clk = i[0];
      step(i[1], 1, i[0], 6);  // R6 loopback with generator selected
    end

    loopback = 0; use_gen = 0;
    clk_stop = 2'b10;
    tx_fs = 1; tx_clk = 1; fs_pin_in = 0;
    step(1, 0, 1, 7);  // R7 value 10 routes
    tx_fs = 0; fs_pin_in = 1;
    step(0, 0, 1, 7);  // R7
    clk_stop = 2'b11; tx_fs = 1; tx_clk = 0;
    step(1, 0, 0, 7);  // R7 value 11 routes
    loopback = 1; use_gen = 1; lock_ext = 1; tx_fs = 0; tx_clk = 1;
    step(0, 0, 1, 7);  // R7 with loopback both active
    loopback = 0; clk_stop = 2'b00; use_gen = 0; lock_ext = 0;
    step(1, 0, 0, 1);  // R1 back to pin routing

    repeat (3) @(posedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule